// File: doc/BRIEF.md
# Interval Traffic Phase Monitor

This block watches uncore request traffic and proposes a change of link configuration. While each fixed-length interval runs, it counts requests served from local memory and requests served by another socket. When the interval closes, it compares the two totals. The comparison depends on which link mode is active. In narrow-link mode, heavier remote traffic leads to a request for wide-link mode. In wide-link mode, heavier local traffic leads to a request for narrow-link mode.

The interval length is given in clock cycles. By default it is derived from the clock rate so that it equals 0.1 ms, which is the shortest spacing allowed between two switch decisions. A coordination agent carries out each transition and raises a busy flag while it works. While that flag is high the monitor stays silent, and it starts a fresh interval once the flag drops. The output is a one-cycle request pulse together with the requested direction.

Top module: `xlink_phase_monitor`

## Requirements
- R1: An interval lasts INTERVAL_CYC cycles. The decision for an interval appears on `switch_req_o` in the cycle that follows the last cycle of that interval, and it lasts exactly one cycle. The pulses sampled in every cycle of the interval, including the last one, take part in the decision.
- R2: When `mode_wide_i` is 0 (narrow) and the remote total is strictly greater than the local total, a request is issued with `to_wide_o` = 1.
- R3: When `mode_wide_i` is 1 (wide) and the local total is strictly greater than the remote total, a request is issued with `to_wide_o` = 0.
- R4: No request is issued if the totals are equal, if the narrow mode sees local ≥ remote, or if the wide mode sees remote ≥ local.
- R5: Both totals return to zero at every interval boundary, so one interval's traffic has no influence on the next interval's decision.
- R6: Each total saturates at 2^CNT_W−1 and never wraps.
- R7: When a local pulse and a remote pulse arrive in the same cycle, both are counted.
- R8: While `agent_busy_i` is high, no request is issued and the timer and both totals are held cleared. This also applies when busy rises in the last cycle of an interval. A new interval begins in the cycle after busy falls.
- R9: During reset and after it, `switch_req_o` and `to_wide_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| local_hit_i | input | 1 | One pulse per uncore request served locally |
| remote_hit_i | input | 1 | One pulse per uncore request served by a remote socket |
| mode_wide_i | input | 1 | Current link mode: 0 narrow, 1 wide |
| agent_busy_i | input | 1 | Coordination agent is performing a transition |
| switch_req_o | output | 1 | One-cycle switch request |
| to_wide_o | output | 1 | Requested direction: 1 to wide, 0 to narrow; valid with the request |

## Verification
The bench builds the block with INTERVAL_CYC = 12 and CNT_W = 3. With these values a whole interval fits in a few dozen cycles, and a total reaches its ceiling of 7 after only a handful of pulses. Both saturation and the difference between saturating and wrapping can therefore be shown directly: two unequal streams larger than 7 compare as equal. The short interval also allows back-to-back intervals, pulses placed only in the last cycle, and busy raised on the boundary cycle to be tested at exact cycle positions.

// File: rtl/phmon_pkg.sv
package phmon_pkg;
  typedef enum logic {
    LINK_NARROW = 1'b0,
    LINK_WIDE   = 1'b1
  } link_mode_e;

  localparam int unsigned NUM_SRC    = 2;
  localparam int unsigned SRC_LOCAL  = 0;
  localparam int unsigned SRC_REMOTE = 1;
endpackage

// File: rtl/phmon_rst_sync.sv
module phmon_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/phmon_interval_timer.sv
module phmon_interval_timer #(
  parameter int unsigned INTERVAL_CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic last_o
);
  localparam int unsigned TW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [TW-1:0] LAST_VAL = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          at_last;

  always_comb begin
    at_last = (tmr_q == LAST_VAL);
    if (restart_i || at_last) tmr_d = '0;
    else                      tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_q <= '0;
    else         tmr_q <= tmr_d;
  end

  assign last_o = at_last && !restart_i;
endmodule

// File: rtl/phmon_sat_counter.sv
module phmon_sat_counter #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] tally_o
);
  localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, sum;
  logic             at_ceil, upd_en;

  always_comb begin
    at_ceil = (cnt_q == CEIL);
    sum     = at_ceil ? cnt_q : cnt_q + CNT_W'(inc_i);
    upd_en  = clr_i || (inc_i && !at_ceil);
    cnt_d   = clr_i ? '0 : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (upd_en) cnt_q <= cnt_d;
  end

  // Total including the current cycle's pulse, used for the boundary decision
  assign tally_o = sum;
endmodule

// File: rtl/phmon_decide.sv
module phmon_decide
  import phmon_pkg::*;
#(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eval_i,
  input  link_mode_e       mode_i,
  input  logic [CNT_W-1:0] local_i,
  input  logic [CNT_W-1:0] remote_i,
  output logic             req_o,
  output logic             to_wide_o
);
  logic want_wide, want_narrow, fire;
  logic req_q, dir_q;

  always_comb begin
    want_wide   = (mode_i == LINK_NARROW) && (remote_i > local_i);
    want_narrow = (mode_i == LINK_WIDE)   && (local_i > remote_i);
    fire        = eval_i && (want_wide || want_narrow);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= fire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dir_q <= 1'b0;
    else if (fire) dir_q <= want_wide;
  end

  assign req_o     = req_q;
  assign to_wide_o = dir_q;
endmodule

// File: rtl/xlink_phase_monitor.sv
module xlink_phase_monitor
  import phmon_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 50_000_000,
  parameter int unsigned INTERVAL_CYC = CLK_HZ / 10_000,
  parameter int unsigned CNT_W        = $clog2(INTERVAL_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic local_hit_i,
  input  logic remote_hit_i,
  input  logic mode_wide_i,
  input  logic agent_busy_i,
  output logic switch_req_o,
  output logic to_wide_o
);
  logic                 rst_n_s;
  logic                 boundary;
  logic                 clr_all;
  logic [NUM_SRC-1:0]   hit_vec;
  logic [CNT_W-1:0]     tally [NUM_SRC];

  phmon_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  phmon_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .restart_i (agent_busy_i),
    .last_o    (boundary)
  );

  assign clr_all             = boundary || agent_busy_i;
  assign hit_vec[SRC_LOCAL]  = local_hit_i;
  assign hit_vec[SRC_REMOTE] = remote_hit_i;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    phmon_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_s),
      .inc_i   (hit_vec[s]),
      .clr_i   (clr_all),
      .tally_o (tally[s])
    );
  end

  phmon_decide #(.CNT_W(CNT_W)) u_decide (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .eval_i    (boundary),
    .mode_i    (link_mode_e'(mode_wide_i)),
    .local_i   (tally[SRC_LOCAL]),
    .remote_i  (tally[SRC_REMOTE]),
    .req_o     (switch_req_o),
    .to_wide_o (to_wide_o)
  );
endmodule

// File: rtl/xlink_phase_monitor_chk.sv
module xlink_phase_monitor_chk #(
  parameter int unsigned INTERVAL_CYC = 5000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_wide_i,
  input logic agent_busy_i,
  input logic switch_req_o,
  input logic to_wide_o
);
  localparam int unsigned GW = $clog2(INTERVAL_CYC + 1);
  localparam logic [GW-1:0] GAP_CAP = GW'(INTERVAL_CYC);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               gap_q <= '0;
    else if (switch_req_o)     gap_q <= GW'(1);
    else if (gap_q != GAP_CAP) gap_q <= gap_q + 1'b1;
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_req_o |=> !switch_req_o); // R1

  AST_MIN_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_req_o |-> (gap_q >= GAP_CAP)); // R1

  AST_DIR_OPPOSES_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_req_o |-> (to_wide_o == !$past(mode_wide_i))); // R2 R3

  AST_BUSY_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(agent_busy_i) |-> !switch_req_o); // R8

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_IDLE: assert (!switch_req_o && !to_wide_o); // R9
  end
endmodule

bind xlink_phase_monitor xlink_phase_monitor_chk #(.INTERVAL_CYC(INTERVAL_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_wide_i  (mode_wide_i),
  .agent_busy_i (agent_busy_i),
  .switch_req_o (switch_req_o),
  .to_wide_o    (to_wide_o)
);

// File: tb/tb_xlink_phase_monitor.sv
`timescale 1ns/1ps
module tb_xlink_phase_monitor;
  localparam int N     = 12;
  localparam int CW    = 3;
  localparam int CEIL  = (1 << CW) - 1;
  localparam int WD_CYC = 200_000;

  logic clk = 1'b0;
  logic rst_n, loc, rem, wide, busy;
  logic req, dir;

  typedef struct {
    int    due;
    bit    req;
    bit    dir;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   chk_cnt = 0;
  int   fail_cnt = 0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xlink_phase_monitor #(.INTERVAL_CYC(N), .CNT_W(CW)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .local_hit_i  (loc),
    .remote_hit_i (rem),
    .mode_wide_i  (wide),
    .agent_busy_i (busy),
    .switch_req_o (req),
    .to_wide_o    (dir)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // Scoreboard monitor: compares every cycle; an expected item is due at one cycle
  always @(negedge clk) begin
    if (mon_en) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t it;
        it = q.pop_front();
        check(req == it.req, it.tag, "request at boundary", int'(req), int'(it.req));
        if (it.req) check(dir == it.dir, it.tag, "direction", int'(dir), int'(it.dir));
      end else begin
        check(req == 1'b0, "R1", "no request off boundary", int'(req), 0);
      end
    end
  end

  // Driver: one interval of N cycles; pulses at the start or the end of it
  task automatic run_interval(input int nl, input int nr, input bit md,
                              input bit restart, input bit tail, input string tag);
    int el, er;
    exp_t it;
    wide = md;
    if (restart) begin
      busy = 1'b1; loc = 1'b0; rem = 1'b0;
      @(negedge clk);
      busy = 1'b0;
    end
    el = (nl > CEIL) ? CEIL : nl;
    er = (nr > CEIL) ? CEIL : nr;
    for (int k = 0; k < N; k++) begin
      if (tail) begin loc = (k >= N - nl); rem = (k >= N - nr); end
      else      begin loc = (k < nl);      rem = (k < nr);      end
      if (k == N - 1) begin
        it.due = cyc + 1;
        it.req = (!md && er > el) || (md && el > er);
        it.dir = !md;
        it.tag = tag;
        q.push_back(it);
      end
      @(negedge clk);
    end
    loc = 1'b0; rem = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; loc = 1'b0; rem = 1'b0; wide = 1'b0; busy = 1'b0;
    repeat (3) @(negedge clk);
    check(req == 1'b0 && dir == 1'b0, "R9", "outputs in reset", int'({req, dir}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req == 1'b0 && dir == 1'b0, "R9", "outputs after reset", int'({req, dir}), 0);
    mon_en = 1'b1;

    run_interval(2, 5, 1'b0, 1'b1, 1'b0, "R2");   // narrow, remote heavier
    run_interval(5, 2, 1'b0, 1'b1, 1'b0, "R4");   // narrow, local heavier
    run_interval(4, 4, 1'b0, 1'b1, 1'b0, "R4");   // equal
    run_interval(6, 3, 1'b1, 1'b1, 1'b0, "R3");   // wide, local heavier
    run_interval(3, 6, 1'b1, 1'b1, 1'b0, "R4");   // wide, remote heavier
    run_interval(4, 4, 1'b1, 1'b1, 1'b0, "R4");   // wide, equal
    run_interval(9, 12, 1'b0, 1'b1, 1'b0, "R6");  // both saturate -> equal
    run_interval(12, 7, 1'b0, 1'b1, 1'b0, "R6");  // 7 vs 7
    run_interval(5, 6, 1'b0, 1'b1, 1'b0, "R7");   // overlapping pulses
    run_interval(0, 1, 1'b0, 1'b1, 1'b1, "R1");   // single pulse in last cycle
    run_interval(6, 0, 1'b0, 1'b1, 1'b0, "R5");   // local-heavy interval...
    run_interval(0, 2, 1'b0, 1'b0, 1'b0, "R5");   // ...then back-to-back remote
    run_interval(1, 0, 1'b1, 1'b0, 1'b1, "R3");   // back-to-back, wide

    // R8: busy mid-interval discards earlier pulses
    wide = 1'b0; busy = 1'b1;
    @(negedge clk);
    busy = 1'b0; rem = 1'b1;
    repeat (5) @(negedge clk);
    rem = 1'b0; busy = 1'b1;
    repeat (2) @(negedge clk);
    busy = 1'b0;
    run_interval(0, 0, 1'b0, 1'b0, 1'b0, "R8");

    // R8: busy held across a full interval of remote traffic
    busy = 1'b1; rem = 1'b1;
    repeat (N + 4) @(negedge clk);
    busy = 1'b0; rem = 1'b0;

    // R8: busy rises exactly in the boundary cycle
    busy = 1'b1;
    @(negedge clk);
    busy = 1'b0; rem = 1'b1;
    repeat (N - 1) @(negedge clk);
    busy = 1'b1;
    @(negedge clk);
    busy = 1'b0; rem = 1'b0;
    repeat (3) @(negedge clk);

    run_interval(1, 3, 1'b0, 1'b1, 1'b0, "R8");   // resumes normally afterwards
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R1", "pending expectations", q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      chk_cnt++;
      fail_cnt++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", WD_CYC, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
      $finish;
    end
  end
endmodule